// File: doc/BRIEF.md
# Encoder Host-Port Configuration Register Bank

This block holds the byte-wide configuration registers of a video encoder behind a plain host access port made of an address, write data, a write strobe, a read strobe and registered read data. Sixteen general configuration bytes and one control byte can be written and read. The control byte carries a software reset bit that clears itself. Writing that bit returns the whole bank to its power-on values.

For board-level connectivity testing, three read-only addresses report the levels present on the 16-bit pixel input bus and on the horizontal sync, vertical sync and subcarrier-lock inputs. The inputs are sampled on the bank clock, which is also the pixel clock, through two register stages. A read therefore returns a settled snapshot. The readback works only while the input-mode field of configuration byte 0x01 selects the standard-definition mode. In every other mode the readback addresses read zero.

A high-to-low transition on the hardware reset input reloads every register in the same way as the software reset.

Top module: `enc_cfg_regbank`

## Requirements
- R1: A write to address 0x00..0x0F stores the full byte. A read strobe captures the addressed value into the read data on the same clock edge, and that value comes from before any write on the same edge.
- R2: After reset, address 0x01 reads 0x00. Every other address a in 0x00..0x0F reads (a*37+17) mod 256. Address 0x17 reads 0x00.
- R3: Address 0x13 returns pixel bits [7:0] and address 0x14 returns bits [15:8]. Address 0x16 returns the horizontal sync in bit 0, the vertical sync in bit 1 and subcarrier lock in bit 2, with bits [7:3] at zero. A read strobed at edge k returns the pin levels sampled at edge k-2.
- R4: When bits [6:4] of address 0x01 are not 3'b000, reads of 0x13, 0x14 and 0x16 return 0x00.
- R5: Writes to 0x13, 0x14 and 0x16 are ignored, and these addresses go on reporting the pin levels.
- R6: Reads of any address outside 0x00..0x0F, 0x13, 0x14, 0x16 and 0x17 return 0x00, and writes to such an address change nothing.
- R7: At the first clock edge at which the hardware reset input is sampled low after being sampled high, every register, both capture stages and the read data return to their reset values. The read data resets to 0x00.
- R8: If a write to 0x17 has bit 1 set, that write is not stored, and on the next clock edge the bank resets exactly as in R7. Bit 1 of 0x17 always reads 0. A write to 0x17 with bit 1 clear stores the byte.
- R9: The read data holds its value on every edge that carries no read strobe and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, also the pixel clock used for pin capture |
| hw_rst_n | input | 1 | Hardware reset; a falling transition resets the bank |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| pix_in | input | 16 | Pixel input bus levels |
| hsync_in | input | 1 | Horizontal sync input level |
| vsync_in | input | 1 | Vertical sync input level |
| sfl_in | input | 1 | Subcarrier-lock input level |

## Verification
A register read is due one edge after its strobe. A pin readback reflects the levels sampled two edges before the strobe edge. A hardware reset lands on the edge where the falling level is first seen, and a software reset lands one edge after the write that requests it. The reference model in the bench advances on every rising edge in that same order: reset first, then read of the old state, then the write, then the capture stages. The read data is compared with the model at every falling edge. Directed checks drive their inputs at a falling edge and sample one full cycle later. In the pin-latency test the bench holds the strobe for three edges after changing the pins and expects the old, old, then new value.

// File: rtl/enc_cfg_pkg.sv
package enc_cfg_pkg;

    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int PIX_W   = 16;
    localparam int NUM_RW  = 16;
    localparam int STAGES  = 2;

    localparam int MODE_IDX = 1;
    localparam int MODE_LSB = 4;
    localparam int MODE_W   = 3;
    localparam int SWRST_BIT = 1;

    localparam logic [AW-1:0] ADDR_RB_LO   = 8'h13;
    localparam logic [AW-1:0] ADDR_RB_HI   = 8'h14;
    localparam logic [AW-1:0] ADDR_RB_SYNC = 8'h16;
    localparam logic [AW-1:0] ADDR_CTRL    = 8'h17;

    // one captured sample of the input pins
    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             sfl;
        logic             vsync;
        logic             hsync;
    } pin_snap_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RW,
        SEL_CTRL,
        SEL_RB_LO,
        SEL_RB_HI,
        SEL_RB_SYNC
    } rd_sel_e;

    // power-on value of general configuration byte idx
    function automatic logic [DW-1:0] cfg_default(input int idx);
        if (idx == MODE_IDX) begin
            return '0;
        end
        return DW'((idx * 37 + 17) % 256);
    endfunction

endpackage

// File: rtl/enc_cfg_reset_ctl.sv
module enc_cfg_reset_ctl (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sw_req,
    output logic bank_rst
);
    logic pin_q;
    logic sw_pend;
    logic hw_fall;

    always_ff @(posedge clk) begin
        pin_q <= hw_rst_n;
    end

    assign hw_fall = pin_q & ~hw_rst_n;

    // software request is acted on one edge after the write
    always_ff @(posedge clk) begin
        if (bank_rst) begin
            sw_pend <= 1'b0;
        end else begin
            sw_pend <= sw_req;
        end
    end

    assign bank_rst = hw_fall | sw_pend;

endmodule

// File: rtl/enc_cfg_pin_capture.sv
module enc_cfg_pin_capture
    import enc_cfg_pkg::*;
#(
    parameter int DEPTH = STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_snap_t pins_in,
    output pin_snap_t snap_out
);
    pin_snap_t stg [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= pins_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= stg[s-1];
                end
            end
        end
    end

    assign snap_out = stg[DEPTH-1];

endmodule

// File: rtl/enc_cfg_rw_store.sv
module enc_cfg_rw_store
    import enc_cfg_pkg::*;
#(
    parameter int NUM = NUM_RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] regs [NUM],
    output logic [DW-1:0] ctrl_q,
    output logic          sw_req
);
    logic ctrl_hit;

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= cfg_default(g);
            end else if (wr_en && addr == AW'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign ctrl_hit = wr_en && (addr == ADDR_CTRL);
    assign sw_req   = ctrl_hit && wdata[SWRST_BIT];

    // a reset-requesting write is not kept
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_hit && !wdata[SWRST_BIT]) begin
            ctrl_q <= wdata;
        end
    end

endmodule

// File: rtl/enc_cfg_read_port.sv
module enc_cfg_read_port
    import enc_cfg_pkg::*;
#(
    parameter int NUM = NUM_RW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     regs [NUM],
    input  logic [DW-1:0]     ctrl_q,
    input  pin_snap_t         snap,
    input  logic [MODE_W-1:0] mode,
    output logic [DW-1:0]     rdata
);
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    rd_sel_e       sel;
    logic          rb_ok;
    logic [DW-1:0] rd_val;

    always_comb begin
        if (int'(addr) < NUM) begin
            sel = SEL_RW;
        end else begin
            case (addr)
                ADDR_CTRL:    sel = SEL_CTRL;
                ADDR_RB_LO:   sel = SEL_RB_LO;
                ADDR_RB_HI:   sel = SEL_RB_HI;
                ADDR_RB_SYNC: sel = SEL_RB_SYNC;
                default:      sel = SEL_NONE;
            endcase
        end
    end

    assign rb_ok = (mode == '0);

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_RW:      rd_val = regs[addr[IDX_W-1:0]];
            SEL_CTRL:    rd_val = ctrl_q;
            SEL_RB_LO:   if (rb_ok) rd_val = snap.pix[PIX_W/2-1:0];
            SEL_RB_HI:   if (rb_ok) rd_val = snap.pix[PIX_W-1:PIX_W/2];
            SEL_RB_SYNC: if (rb_ok) rd_val = {{(DW-3){1'b0}}, snap.sfl, snap.vsync, snap.hsync};
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

endmodule

// File: rtl/enc_cfg_regbank.sv
module enc_cfg_regbank
    import enc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              sfl_in
);
    logic              bank_rst;
    logic              sw_req;
    logic [DW-1:0]     rw_regs [NUM_RW];
    logic [DW-1:0]     ctrl_q;
    logic [MODE_W-1:0] cfg_mode;
    pin_snap_t         pins_now;
    pin_snap_t         pins_held;

    assign pins_now = {pix_in, sfl_in, vsync_in, hsync_in};
    assign cfg_mode = rw_regs[MODE_IDX][MODE_LSB +: MODE_W];

    enc_cfg_reset_ctl u_rst (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .sw_req   (sw_req),
        .bank_rst (bank_rst)
    );

    enc_cfg_pin_capture #(.DEPTH(STAGES)) u_cap (
        .clk      (clk),
        .rst      (bank_rst),
        .pins_in  (pins_now),
        .snap_out (pins_held)
    );

    enc_cfg_rw_store #(.NUM(NUM_RW)) u_store (
        .clk    (clk),
        .rst    (bank_rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .regs   (rw_regs),
        .ctrl_q (ctrl_q),
        .sw_req (sw_req)
    );

    enc_cfg_read_port #(.NUM(NUM_RW)) u_rd (
        .clk    (clk),
        .rst    (bank_rst),
        .rd_en  (rd_en),
        .addr   (addr),
        .regs   (rw_regs),
        .ctrl_q (ctrl_q),
        .snap   (pins_held),
        .mode   (cfg_mode),
        .rdata  (rdata)
    );

endmodule

// File: rtl/enc_cfg_regbank_chk.sv
module enc_cfg_regbank_chk (
    input logic       clk,
    input logic       hw_rst_n,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       bank_rst,
    input logic [2:0] mode
);
    logic seen     = 1'b0;
    logic pin_prev = 1'b0;
    logic fall_now;
    logic rb_addr;
    logic known_addr;

    assign fall_now   = pin_prev & ~hw_rst_n;
    assign rb_addr    = (addr == 8'h13) || (addr == 8'h14) || (addr == 8'h16);
    assign known_addr = (addr < 8'h10) || rb_addr || (addr == 8'h17);

    always_ff @(posedge clk) begin
        pin_prev <= hw_rst_n;
        if (fall_now) seen <= 1'b1;
    end

    AST_FALL_RESETS: assert property (@(posedge clk) disable iff (!seen)
        fall_now |-> bank_rst);                                        // R7
    AST_RESET_ZERO_RDATA: assert property (@(posedge clk) disable iff (!seen)
        bank_rst |=> (rdata == 8'h00));                                // R7
    AST_SWRST_NEXT_EDGE: assert property (@(posedge clk) disable iff (!seen)
        (wr_en && addr == 8'h17 && wdata[1] && !bank_rst) |=> bank_rst); // R8
    AST_CTRL_BIT_LOW: assert property (@(posedge clk) disable iff (!seen)
        (rd_en && addr == 8'h17) |=> !rdata[1]);                       // R8
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!seen)
        (rd_en && rb_addr && mode != 3'b000) |=> (rdata == 8'h00));    // R4
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!seen)
        (rd_en && !known_addr) |=> (rdata == 8'h00));                  // R6
    AST_SYNC_PAD: assert property (@(posedge clk) disable iff (!seen)
        (rd_en && addr == 8'h16) |=> (rdata[7:3] == 5'b0));            // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!seen)
        (!rd_en && !bank_rst) |=> $stable(rdata));                     // R9

endmodule

bind enc_cfg_regbank enc_cfg_regbank_chk u_chk (
    .clk      (clk),
    .hw_rst_n (hw_rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .bank_rst (bank_rst),
    .mode     (cfg_mode)
);

// File: tb/tb_enc_cfg_regbank.sv
module tb_enc_cfg_regbank;

    logic        clk = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] pix_in = '0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        sfl_in = 1'b0;

    always #10 clk = ~clk;

    enc_cfg_regbank dut (
        .clk(clk), .hw_rst_n(hw_rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pix_in(pix_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .sfl_in(sfl_in)
    );

    int    total = 0;
    int    bad = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_reg [16];
    int m_ctrl = 0;
    int m_s1 = 0;
    int m_s2 = 0;
    int m_rdata = 0;
    bit m_pend = 0;
    bit m_prev = 0;

    function automatic int dflt(input int i);
        return (i == 1) ? 0 : ((i * 37 + 17) % 256);
    endfunction

    function automatic int m_read(input int a);
        int mode;
        mode = (m_reg[1] >> 4) & 7;
        if (a < 16) return m_reg[a];
        if (a == 8'h17) return m_ctrl;
        if (a == 8'h13) return (mode != 0) ? 0 : (m_s2 & 255);
        if (a == 8'h14) return (mode != 0) ? 0 : ((m_s2 >> 8) & 255);
        if (a == 8'h16) return (mode != 0) ? 0 : ((m_s2 >> 16) & 7);
        return 0;
    endfunction

    always @(posedge clk) begin
        bit fall;
        fall = m_prev && !hw_rst_n;
        m_prev = hw_rst_n;
        if (fall || m_pend) begin
            for (int i = 0; i < 16; i++) m_reg[i] = dflt(i);
            m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_rdata = 0; m_pend = 0;
        end else begin
            if (rd_en) m_rdata = m_read(int'(addr));
            m_pend = wr_en && addr == 8'h17 && wdata[1];
            if (wr_en) begin
                if (addr < 8'h10) m_reg[addr[3:0]] = int'(wdata);
                else if (addr == 8'h17 && !wdata[1]) m_ctrl = int'(wdata);
            end
            m_s2 = m_s1;
            m_s1 = int'(pix_in) | (int'(hsync_in) << 16) | (int'(vsync_in) << 17) | (int'(sfl_in) << 18);
        end
    end

    always @(negedge clk) begin
        if (started && !done) check(cur_req, int'(rdata), m_rdata, "per-cycle model compare");
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [15:0] p, input logic h, input logic v, input logic s);
        pix_in = p; hsync_in = h; vsync_in = v; sfl_in = s;
    endtask

    task automatic hw_pulse();
        hw_rst_n = 1'b0;
        @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL all watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int v2;
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        @(negedge clk);
        idle(2);
        hw_pulse();
        started = 1;

        // R2 defaults
        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            rd(8'(i), v);
            check("R2", v, dflt(i), "default value");
        end
        rd(8'h17, v);
        check("R2", v, 0, "control default");

        // R1 write/read patterns
        cur_req = "R1";
        for (int i = 0; i < 16; i++) wr(8'(i), 8'((i * 8'h5B) ^ 8'hA5));
        wr(8'h03, 8'h00);
        wr(8'h04, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            int e;
            e = (i == 3) ? 0 : (i == 4) ? 255 : (((i * 8'h5B) ^ 8'hA5) & 255);
            rd(8'(i), v);
            check("R1", v, e, "stored byte");
        end

        // R3 pin readback, mode 000
        cur_req = "R3";
        wr(8'h01, 8'h00);
        set_pins(16'hBEEF, 1'b1, 1'b0, 1'b1);
        idle(3);
        rd(8'h13, v);  check("R3", v, 8'hEF, "pixel low byte");
        rd(8'h14, v);  check("R3", v, 8'hBE, "pixel high byte");
        rd(8'h16, v);  check("R3", v, 8'h05, "sync bits");
        set_pins(16'h1234, 1'b0, 1'b1, 1'b0);
        addr = 8'h13; rd_en = 1'b1;
        @(negedge clk); v = int'(rdata); check("R3", v, 8'hEF, "latency edge k");
        @(negedge clk); v = int'(rdata); check("R3", v, 8'hEF, "latency edge k+1");
        @(negedge clk); v = int'(rdata); check("R3", v, 8'h34, "latency edge k+2");
        rd_en = 1'b0;
        rd(8'h16, v);  check("R3", v, 8'h02, "sync bits vsync only");

        // R4 mode gate
        cur_req = "R4";
        wr(8'h01, 8'h20);
        rd(8'h13, v);  check("R4", v, 0, "low byte in other mode");
        rd(8'h14, v);  check("R4", v, 0, "high byte in other mode");
        rd(8'h16, v);  check("R4", v, 0, "sync in other mode");
        wr(8'h01, 8'h8F);
        rd(8'h14, v);  check("R4", v, 8'h12, "mode 000 with other bits set");

        // R5 read-only writes ignored
        cur_req = "R5";
        wr(8'h13, 8'hAA); wr(8'h14, 8'h55); wr(8'h16, 8'hFF);
        rd(8'h13, v);  check("R5", v, 8'h34, "0x13 after write");
        rd(8'h14, v);  check("R5", v, 8'h12, "0x14 after write");
        rd(8'h16, v);  check("R5", v, 8'h02, "0x16 after write");

        // R6 unmapped
        cur_req = "R6";
        wr(8'h20, 8'h99); wr(8'h15, 8'h77); wr(8'hFF, 8'h11);
        rd(8'h20, v);  check("R6", v, 0, "0x20");
        rd(8'h15, v);  check("R6", v, 0, "0x15");
        rd(8'h12, v);  check("R6", v, 0, "0x12");
        rd(8'hFF, v);  check("R6", v, 0, "0xFF");
        rd(8'h00, v);  check("R6", v, 8'hA5, "0x00 untouched by unmapped writes");

        // R9 hold
        cur_req = "R9";
        rd(8'h04, v);
        idle(5);
        check("R9", int'(rdata), v, "rdata held without strobe");

        // R7 hardware reset
        cur_req = "R7";
        wr(8'h05, 8'h3C);
        hw_pulse();
        check("R7", int'(rdata), 0, "rdata after falling edge");
        rd(8'h05, v);  check("R7", v, dflt(5), "reg 5 default");
        rd(8'h01, v);  check("R7", v, 0, "mode default");

        // R8 software reset
        cur_req = "R8";
        wr(8'h17, 8'h05);
        rd(8'h17, v);  check("R8", v, 8'h05, "control stored with bit1 clear");
        wr(8'h02, 8'h77);
        wr(8'h17, 8'hF2);
        idle(1);
        rd(8'h17, v);  check("R8", v, 0, "control after sw reset");
        rd(8'h02, v2); check("R8", v2, dflt(2), "reg 2 after sw reset");

        // mixed traffic against the model
        cur_req = "R1";
        for (int n = 0; n < 600; n++) begin
            int op;
            int sel;
            logic [7:0] a;
            op  = $urandom_range(0, 9);
            sel = $urandom_range(0, 7);
            case (sel)
                0, 1, 2: a = 8'($urandom_range(0, 15));
                3:       a = 8'h13;
                4:       a = 8'h14;
                5:       a = 8'h16;
                6:       a = 8'h17;
                default: a = 8'($urandom_range(16, 255));
            endcase
            if ($urandom_range(0, 3) == 0)
                set_pins(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            addr  = a;
            wdata = 8'($urandom);
            wr_en = (op < 4);
            rd_en = (op >= 3 && op < 9);
            hw_rst_n = ($urandom_range(0, 99) != 0);
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0; hw_rst_n = 1'b1;
        end
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule